// File: doc/BRIEF.md
# Register-Controlled SPI Master Transaction Engine

This block runs complete SPI frames on behalf of a host that only writes registers. The host loads a 16-bit command word (opcode byte over address byte) and a 24-bit right-aligned data word. It then writes a control word that carries a byte-count code, clock polarity, clock phase, a read/write direction bit, a clock divider value and a start bit. The engine lowers the single chip select and clocks out the command bytes, then the data bytes. In a read it captures the returned data bytes back into the data register. The opcode is never decoded, so any command value passes through unchanged. The direction bit alone decides whether the data phase sends or receives.

The byte-count code gives the length of the whole frame, command bytes included. A write sends code+1 bytes, from the opcode alone up to opcode, address and three data bytes. A read always sends both command bytes and receives one to three bytes. All four clock modes are supported. The serial clock half period is a programmable number of system clocks.

Top module: `spi_txn_master`

## Requirements
- R1: After reset: cs_n=1, sck=0, mosi=0, busy=0, done=0 and data_reg=0.
- R2: A write to address 0 loads the command from wr_data[15:0], and address 1 loads data_reg from wr_data[23:0]. Address 2 loads control: code [2:0], cpol [3], cpha [4], read [5], start [6] and divider [15:8]. A control write with bit 6 set while idle starts a frame that uses the fields of that same write.
- R3: In a write (bit 5 = 0), the frame has min(code,4)+1 bytes in this order: command[15:8], command[7:0], then the data bytes. With k data bytes, the data bytes run from data_reg[8k-1:8k-8] down to data_reg[7:0]. Every byte goes MSB first, and data_reg keeps its value.
- R4: In a read (bit 5 = 1), the frame has code+1 bytes, with the code clamped to 2..4. Both command bytes are sent, and mosi is 0 during the data bytes. The MISO bits of the data bytes enter MSB first. At frame end they land right-aligned in data_reg, with the unused upper bytes cleared.
- R5: sck idles at cpol. With cpha=0, the first bit is on mosi when cs_n falls, and bits are sampled on the leading sck edge. With cpha=1, mosi changes on the leading edge and bits are sampled on the trailing edge. A frame of B bytes has 16·B sck edges and ends with sck at cpol.
- R6: Each sck half period, including the lead from cs_n falling and the lag before cs_n rises, lasts divider+1 clocks. cs_n stays low for (16·B+2)·(divider+1) clocks.
- R7: busy rises in the clock after the accepted start write and falls in the clock that cs_n rises. done is high for exactly that one clock.
- R8: Register writes of any kind made while busy, including start requests, are ignored. The running frame, data_reg and the configuration are left untouched, and no second frame follows.
- R9: A start write issued during the clock in which done is high is accepted, so cs_n is high for exactly one clock between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 command, 1 data, 2 control |
| wr_data | input | 24 | Register write value |
| miso | input | 1 | Serial data from the slave |
| data_reg | output | 24 | Current data register contents |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at frame end |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip select |

## Verification
The end of one frame and the start of the next can fall in the same clock. The done pulse and the chip-select release happen in that clock, and a start write made in that same clock must still be accepted. The bench provokes this by waiting for done to be high and driving a control write with the start bit in that very cycle. The new write changes the mode, direction and length. It judges the result by requiring cs_n to be low again one clock later with busy high. The second frame's bit stream, edge count, chip-select width and captured read data must then match the new configuration exactly.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;

  localparam int CMD_W     = 16;
  localparam int DATA_W    = 24;
  localparam int FRAME_W   = CMD_W + DATA_W;
  localparam int MAX_BYTES = FRAME_W / 8;
  localparam int BYTES_W   = $clog2(MAX_BYTES + 1);
  localparam int EDGE_W    = $clog2(16 * MAX_BYTES);
  localparam int MIN_RD_BYTES = CMD_W / 8 + 1;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int CTRL_CODE_LSB = 0;
  localparam int CTRL_CODE_W   = 3;
  localparam int CTRL_CPOL     = 3;
  localparam int CTRL_CPHA     = 4;
  localparam int CTRL_RD       = 5;
  localparam int CTRL_GO       = 6;
  localparam int CTRL_DIV_LSB  = 8;

  typedef struct packed {
    logic rd;
    logic cpha;
    logic cpol;
  } spi_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL
  } eng_state_e;

  // Total frame length in bytes from the count code and the direction.
  function automatic logic [BYTES_W-1:0] frame_bytes(
    input logic [CTRL_CODE_W-1:0] code,
    input logic                   rd
  );
    int unsigned n;
    n = int'(code) + 1;
    if (n > MAX_BYTES) n = MAX_BYTES;
    if (rd && n < MIN_RD_BYTES) n = MIN_RD_BYTES;
    return BYTES_W'(n);
  endfunction

  // Left-aligned bit image of the frame: command, then the data bytes in use.
  function automatic logic [FRAME_W-1:0] frame_image(
    input logic [CMD_W-1:0]   cmd,
    input logic [DATA_W-1:0]  data,
    input logic [BYTES_W-1:0] nbytes,
    input logic               rd
  );
    logic [DATA_W-1:0] aligned;
    int unsigned       dn;
    dn = (int'(nbytes) > CMD_W / 8) ? int'(nbytes) - CMD_W / 8 : 0;
    if (rd || dn == 0) aligned = '0;
    else               aligned = data << (8 * (DATA_W / 8 - dn));
    return {cmd, aligned};
  endfunction

endpackage

// File: rtl/spi_txn_clkdiv.sv
module spi_txn_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // With a divider above zero, two ticks are never adjacent.
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> !tick);

endmodule

// File: rtl/spi_txn_regs.sv
module spi_txn_regs
  import spi_txn_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               busy,
  input  logic               rx_load,
  input  logic [DATA_W-1:0]  rx_data,
  output logic               launch,
  output spi_mode_t          l_mode,
  output logic [BYTES_W-1:0] l_bytes,
  output logic [FRAME_W-1:0] l_image,
  output logic               idle_cpol,
  output logic [DIV_W-1:0]   div_q,
  output logic [DATA_W-1:0]  data_q
);

  logic [CMD_W-1:0]       cmd_q;
  logic [CTRL_CODE_W-1:0] code_q;
  spi_mode_t              mode_q;
  logic                   wr_ok;

  assign wr_ok = wr_en && !busy;

  assign l_mode.rd   = wr_data[CTRL_RD];
  assign l_mode.cpha = wr_data[CTRL_CPHA];
  assign l_mode.cpol = wr_data[CTRL_CPOL];
  assign l_bytes     = frame_bytes(wr_data[CTRL_CODE_LSB +: CTRL_CODE_W], wr_data[CTRL_RD]);
  assign l_image     = frame_image(cmd_q, data_q, l_bytes, wr_data[CTRL_RD]);
  assign launch      = wr_ok && (wr_addr == ADDR_CTRL) && wr_data[CTRL_GO];
  assign idle_cpol   = mode_q.cpol;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
      code_q <= '0;
      mode_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ok) begin
        case (wr_addr)
          ADDR_CMD:  cmd_q  <= wr_data[CMD_W-1:0];
          ADDR_DATA: data_q <= wr_data;
          ADDR_CTRL: begin
            code_q <= wr_data[CTRL_CODE_LSB +: CTRL_CODE_W];
            mode_q <= l_mode;
            div_q  <= wr_data[CTRL_DIV_LSB +: DIV_W];
          end
          default: ;
        endcase
      end
      if (rx_load) data_q <= rx_data;
    end
  end

  // Configuration cannot move while a frame runs.
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(cmd_q) && $stable(mode_q) && $stable(div_q) && $stable(code_q)));

  // The data register only changes through the read-back load while busy.
  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rx_load)) |-> $stable(data_q));

  // Launched frame length is legal for its direction (also covers R4 clamping).
  assert_bytes_range_R3: assert property (@(posedge clk) disable iff (rst)
    launch |-> (l_bytes >= 1 && l_bytes <= MAX_BYTES && (!l_mode.rd || l_bytes >= MIN_RD_BYTES)));

endmodule

// File: rtl/spi_txn_engine.sv
module spi_txn_engine
  import spi_txn_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  spi_mode_t          l_mode,
  input  logic [BYTES_W-1:0] l_bytes,
  input  logic [FRAME_W-1:0] l_image,
  input  logic               idle_cpol,
  input  logic               tick,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic               cs_n,
  output logic               busy,
  output logic               done,
  output logic               rx_load,
  output logic [DATA_W-1:0]  rx_data
);

  eng_state_e         state_q;
  spi_mode_t          mode_r;
  logic [FRAME_W-1:0] tx_sr;
  logic [DATA_W-1:0]  rx_sr;
  logic [EDGE_W-1:0]  edge_q;
  logic [EDGE_W-1:0]  last_q;
  logic               is_sample;
  logic               in_data;

  // Even edge index = leading edge; sampling edge depends on phase.
  assign is_sample = (edge_q[0] == mode_r.cpha);
  assign in_data   = edge_q[EDGE_W-1:1] >= (EDGE_W-1)'(CMD_W);
  assign rx_load   = (state_q == ST_TRAIL) && tick && mode_r.rd;
  assign rx_data   = rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_r  <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      edge_q  <= '0;
      last_q  <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          sck <= idle_cpol;
          if (launch) begin
            mode_r  <= l_mode;
            sck     <= l_mode.cpol;
            cs_n    <= 1'b0;
            busy    <= 1'b1;
            edge_q  <= '0;
            last_q  <= EDGE_W'({l_bytes, 4'b0000}) - EDGE_W'(1);
            rx_sr   <= '0;
            state_q <= ST_LEAD;
            if (!l_mode.cpha) begin
              mosi  <= l_image[FRAME_W-1];
              tx_sr <= l_image << 1;
            end else begin
              mosi  <= 1'b0;
              tx_sr <= l_image;
            end
          end
        end
        ST_LEAD: begin
          if (tick) state_q <= ST_XFER;
        end
        ST_XFER: begin
          if (tick) begin
            sck    <= ~sck;
            edge_q <= edge_q + 1'b1;
            if (is_sample) begin
              if (mode_r.rd && in_data) rx_sr <= {rx_sr[DATA_W-2:0], miso};
            end else begin
              mosi  <= tx_sr[FRAME_W-1];
              tx_sr <= tx_sr << 1;
            end
            if (edge_q == last_q) state_q <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            cs_n    <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b1;
            mosi    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // done marks exactly the clock in which chip select is released.
  assert_done_release_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !$past(cs_n)));

  // An even number of edges brings the clock back to its idle level.
  assert_sck_idle_end_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (sck == mode_r.cpol));

  // Inside a frame the serial clock only moves on a divider tick.
  assert_sck_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(tick)) |-> $stable(sck));

endmodule

// File: rtl/spi_txn_master.sv
module spi_txn_master
  import spi_txn_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              miso,
  output logic [DATA_W-1:0] data_reg,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n
);

  logic               launch;
  spi_mode_t          l_mode;
  logic [BYTES_W-1:0] l_bytes;
  logic [FRAME_W-1:0] l_image;
  logic               idle_cpol;
  logic [DIV_W-1:0]   div_q;
  logic               tick;
  logic               rx_load;
  logic [DATA_W-1:0]  rx_data;

  spi_txn_regs #(.DIV_W(DIV_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .rx_load   (rx_load),
    .rx_data   (rx_data),
    .launch    (launch),
    .l_mode    (l_mode),
    .l_bytes   (l_bytes),
    .l_image   (l_image),
    .idle_cpol (idle_cpol),
    .div_q     (div_q),
    .data_q    (data_reg)
  );

  spi_txn_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (div_q),
    .tick (tick)
  );

  spi_txn_engine engine_i (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .l_mode    (l_mode),
    .l_bytes   (l_bytes),
    .l_image   (l_image),
    .idle_cpol (idle_cpol),
    .tick      (tick),
    .miso      (miso),
    .sck       (sck),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .busy      (busy),
    .done      (done),
    .rx_load   (rx_load),
    .rx_data   (rx_data)
  );

endmodule

// File: tb/spi_txn_master_tb_top.sv
module spi_txn_master_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [23:0] wr_data = 24'd0;
  logic        miso = 1'b0;
  logic [23:0] data_reg;
  logic        busy, done, sck, mosi, cs_n;

  always #2.5 clk = ~clk;

  spi_txn_master dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .miso(miso), .data_reg(data_reg), .busy(busy), .done(done),
    .sck(sck), .mosi(mosi), .cs_n(cs_n)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Slave model and frame monitor, all at the falling system clock edge.
  logic        m_cpol = 1'b0, m_cpha = 1'b0;
  logic [39:0] spat = 40'd0;
  logic [39:0] cap = 40'd0;
  int          nbits = 0, edges = 0, lowcyc = 0, dones = 0, idx = 0;
  logic        sck_prev = 1'b0, cs_prev = 1'b1, lead;

  always @(negedge clk) begin
    if (!cs_n && cs_prev) begin
      edges = 0; nbits = 0; cap = 40'd0; lowcyc = 1; idx = 39;
      if (!m_cpha) begin miso = spat[39]; idx = 38; end
    end else if (!cs_n) begin
      lowcyc++;
      if (sck != sck_prev) begin
        edges++;
        lead = (sck_prev == m_cpol);
        if (lead != m_cpha) begin
          cap = {cap[38:0], mosi}; nbits++;
        end else begin
          if (idx >= 0) begin miso = spat[idx]; idx--; end
        end
      end
    end
    if (done) dones++;
    sck_prev = sck;
    cs_prev  = cs_n;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [23:0] ctrl_word(input logic rd, input logic cpha, input logic cpol,
                                            input logic [2:0] code, input logic [3:0] div);
    return {8'h00, 4'h0, div, 1'b0, 1'b1, rd, cpha, cpol, code};
  endfunction

  function automatic int exp_bytes(input logic rd, input logic [2:0] code);
    int n;
    n = int'(code) + 1;
    if (n > 5) n = 5;
    if (rd && n < 3) n = 3;
    return n;
  endfunction

  task automatic wait_done();
    int t;
    t = 0;
    while (t < 20000) begin
      @(negedge clk);
      if (done) return;
      t++;
    end
    n_fail++;
    $display("FAIL R7 done timeout: actual %0d expected %0d", 0, 1);
  endtask

  // Called at the negedge where done is high.
  task automatic verify_frame(input logic rd, input logic cpol, input logic [2:0] code,
                              input logic [3:0] div, input logic [15:0] cmd,
                              input logic [23:0] data, input logic [23:0] pat, input int dones0);
    int nb, dn;
    logic [39:0] e;
    logic [23:0] exp_d;
    nb = exp_bytes(rd, code);
    dn = nb - 2;
    e = {32'd0, cmd[15:8]};
    if (nb > 1) e = {e[31:0], cmd[7:0]};
    for (int j = 0; j < dn; j++) begin
      if (rd) e = {e[31:0], 8'h00};
      else    e = {e[31:0], 8'(data >> (8 * (dn - 1 - j)))};
    end
    if (rd) exp_d = pat >> (24 - 8 * dn);
    else    exp_d = data;
    check("R7 cs_n high at done", {39'd0, cs_n}, 40'd1);
    check("R7 busy low at done", {39'd0, busy}, 40'd0);
    if (rd) check("R4 read data", {16'd0, data_reg}, {16'd0, exp_d});
    else    check("R3 data kept", {16'd0, data_reg}, {16'd0, exp_d});
    repeat (2) @(negedge clk);
    if (rd) check("R4 mosi stream", cap, e);
    else    check("R3 mosi stream", cap, e);
    check("R5 bit count", 40'(nbits), 40'(8 * nb));
    check("R5 edge count", 40'(edges), 40'(16 * nb));
    check("R6 cs low width", 40'(lowcyc), 40'((16 * nb + 2) * (int'(div) + 1)));
    check("R7 single done", 40'(dones - dones0), 40'd1);
    check("R5 sck idle", {39'd0, sck}, {39'd0, cpol});
  endtask

  // rd, cpha, cpol, code, div, cmd, data, slave reply
  localparam int NV = 10;
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 3'd4, 4'd1, 16'h02A5, 24'h123456, 24'h000000},
    {1'b0, 1'b1, 1'b1, 3'd2, 4'd0, 16'h0210, 24'hABCDEF, 24'h000000},
    {1'b0, 1'b1, 1'b0, 3'd0, 4'd2, 16'h9F00, 24'h555555, 24'h000000},
    {1'b0, 1'b0, 1'b1, 3'd1, 4'd0, 16'h3C5A, 24'h010203, 24'h000000},
    {1'b0, 1'b0, 1'b0, 3'd6, 4'd0, 16'h0201, 24'h0000FF, 24'h000000},
    {1'b1, 1'b0, 1'b0, 3'd4, 4'd1, 16'h0340, 24'h000000, 24'hC0FFEE},
    {1'b1, 1'b1, 1'b1, 3'd2, 4'd0, 16'h0311, 24'h000000, 24'h8155AA},
    {1'b1, 1'b1, 1'b0, 3'd0, 4'd3, 16'h0322, 24'h000000, 24'h7E1234},
    {1'b1, 1'b0, 1'b1, 3'd7, 4'd0, 16'h0B33, 24'h000000, 24'h5A5A01},
    {1'b1, 1'b0, 1'b0, 3'd3, 4'd0, 16'h0344, 24'h000000, 24'hBEEF99}
  };

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cs_n", {39'd0, cs_n}, 40'd1);
    check("R1 sck", {39'd0, sck}, 40'd0);
    check("R1 mosi", {39'd0, mosi}, 40'd0);
    check("R1 busy", {39'd0, busy}, 40'd0);
    check("R1 done", {39'd0, done}, 40'd0);
    check("R1 data_reg", {16'd0, data_reg}, 40'd0);

    for (int i = 0; i < NV; i++) begin
      logic [73:0] v;
      v = VEC[i];
      wr(2'd0, {8'd0, v[63:48]});
      wr(2'd1, v[73] ? 24'hFFFFFF : v[47:24]);
      check("R2 data write", {16'd0, data_reg}, {16'd0, (v[73] ? 24'hFFFFFF : v[47:24])});
      m_cpol = v[71]; m_cpha = v[72]; spat = {16'hA5C3, v[23:0]};
      wr(2'd2, ctrl_word(v[73], v[72], v[71], v[70:68], v[67:64]));
      check("R7 busy after start", {39'd0, busy}, 40'd1);
      d0 = dones;
      wait_done();
      verify_frame(v[73], v[71], v[70:68], v[67:64], v[63:48], v[47:24], v[23:0], d0);
    end

    // R8: writes during a frame are dropped.
    wr(2'd0, 24'h000255);
    wr(2'd1, 24'h0F0F0F);
    m_cpol = 1'b0; m_cpha = 1'b0; spat = 40'd0;
    wr(2'd2, ctrl_word(1'b0, 1'b0, 1'b0, 3'd4, 4'd3));
    d0 = dones;
    repeat (20) @(negedge clk);
    wr(2'd1, 24'h999999);
    wr(2'd0, 24'h00FFFF);
    wr(2'd2, ctrl_word(1'b1, 1'b0, 1'b1, 3'd0, 4'd0));
    check("R8 data untouched in frame", {16'd0, data_reg}, 40'h0F0F0F);
    wait_done();
    verify_frame(1'b0, 1'b0, 3'd4, 4'd3, 16'h0255, 24'h0F0F0F, 24'h0, d0);
    repeat (10) @(negedge clk);
    check("R8 no hidden start", {39'd0, busy}, 40'd0);
    check("R8 cpol unchanged", {39'd0, sck}, 40'd0);
    check("R8 done count", 40'(dones - d0), 40'd1);

    // R9: start request in the done cycle.
    wr(2'd0, 24'h000277);
    wr(2'd1, 24'h13579B);
    m_cpol = 1'b0; m_cpha = 1'b0; spat = 40'd0;
    wr(2'd2, ctrl_word(1'b0, 1'b0, 1'b0, 3'd4, 4'd1));
    wait_done();
    check("R9 first frame data", {16'd0, data_reg}, 40'h13579B);
    m_cpol = 1'b1; m_cpha = 1'b1; spat = {16'hA5C3, 24'h2468AC};
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = ctrl_word(1'b1, 1'b1, 1'b1, 3'd3, 4'd0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 cs_n low again", {39'd0, cs_n}, 40'd0);
    check("R9 busy again", {39'd0, busy}, 40'd1);
    d0 = dones;
    wait_done();
    verify_frame(1'b1, 1'b1, 3'd3, 4'd0, 16'h0277, 24'h13579B, 24'h2468AC, d0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule